// File: doc/BRIEF.md
# Eight-Entry General-Purpose Register Bank

This block holds the architectural registers of a small 16-bit load/store processor: eight words of 16 bits, selected by 3-bit indices. Two independent read ports return the selected words combinationally, so the decode stage can fetch both source operands in the same cycle that it presents their indices. One write port commits a result on the rising clock edge, but only when its enable is high.

Entry 0 is the constant-zero register. Reads of it always return zero, and any write that targets it is discarded. Five entries that a debugger or test harness needs to watch are wired to dedicated tap outputs. Those outputs are valid at all times and do not depend on the read indices. The index map is fixed: 0 zero, 1 return address, 2 stack pointer, 3 and 4 temporaries, 5 to 7 saved registers s0 to s2. The clock drives every storage flop directly. Write qualification is done in the next-state logic.

Top module: `gpr_bank`

## Requirements
- R1: While `rst_n` is low, and after it is released, every entry reads 0x0000 until it is written.
- R2: With `wr_en` high, the entry chosen by `wr_idx` takes `wr_data` at the rising clock edge. The new value can be read from the first sampling point after that edge.
- R3: With `wr_en` low, no entry changes at the clock edge, whatever `wr_idx` and `wr_data` hold.
- R4: A write changes only the entry chosen by `wr_idx`. All seven other entries keep their values.
- R5: Index 0 reads 0x0000 on both read ports at all times. A write with `wr_idx` = 0 is ignored.
- R6: `rd_a_data` and `rd_b_data` show the entries chosen by `rd_a_idx` and `rd_b_idx` in the same cycle. The two ports are fully independent.
- R7: If a read index equals the write index in the cycle of a write, the read port returns the old value until the clock edge.
- R8: The tap outputs always show fixed entries, regardless of the read indices: `tap_ra` index 1, `tap_sp` index 2, `tap_s0` index 5, `tap_s1` index 6, `tap_s2` index 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, wired straight to all storage flops |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_en | input | 1 | Commit `wr_data` at the next rising edge |
| wr_idx | input | 3 | Destination entry of the write |
| wr_data | input | 16 | Value to write |
| rd_a_idx | input | 3 | Entry selected for read port A |
| rd_a_data | output | 16 | Contents of the entry at `rd_a_idx` |
| rd_b_idx | input | 3 | Entry selected for read port B |
| rd_b_data | output | 16 | Contents of the entry at `rd_b_idx` |
| tap_ra | output | 16 | Contents of entry 1 (return address) |
| tap_sp | output | 16 | Contents of entry 2 (stack pointer) |
| tap_s0 | output | 16 | Contents of entry 5 |
| tap_s1 | output | 16 | Contents of entry 6 |
| tap_s2 | output | 16 | Contents of entry 7 |

## Verification
The bench builds the bank with its default parameters: a 16-bit word, a 3-bit index and eight entries with the standard tap map. With only eight indices, a few thousand random cycles aim many writes at entry 0. They also cover every pairing of a read index with a same-cycle write index, and every tap entry is overwritten many times. Directed steps come first. They cover the post-reset contents, a write to the zero entry, a write presented with the enable low, and a read of the entry being written in the same cycle.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int GPR_DATA_W = 16;
  localparam int GPR_IDX_W  = 3;
  // Architectural index map
  localparam int GPR_IDX_ZERO = 0;
  localparam int GPR_IDX_RA   = 1;
  localparam int GPR_IDX_SP   = 2;
  localparam int GPR_IDX_S0   = 5;
  localparam int GPR_IDX_S1   = 6;
  localparam int GPR_IDX_S2   = 7;
endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
  parameter int IDX_W   = 3,
  parameter int ENTRIES = 1 << IDX_W
) (
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  output logic [ENTRIES-1:1] wr_sel
);
  // Entry 0 has no select line, so a write aimed at it reaches no flop.
  for (genvar g = 1; g < ENTRIES; g++) begin : g_sel
    assign wr_sel[g] = wr_en && (wr_idx == IDX_W'(g));
  end
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage #(
  parameter int DATA_W  = 16,
  parameter int ENTRIES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ENTRIES-1:1]        wr_sel,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [ENTRIES*DATA_W-1:0] q_flat
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    if (g == 0) begin : g_zero
      assign q_flat[0 +: DATA_W] = '0;
    end else begin : g_reg
      logic [DATA_W-1:0] q_r;
      logic [DATA_W-1:0] q_nxt;

      always_comb begin
        q_nxt = q_r;
        if (wr_sel[g]) q_nxt = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
      end

      assign q_flat[g*DATA_W +: DATA_W] = q_r;
    end
  end
endmodule

// File: rtl/gpr_rd_mux.sv
module gpr_rd_mux #(
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 3,
  parameter int ENTRIES = 1 << IDX_W
) (
  input  logic [ENTRIES*DATA_W-1:0] q_flat,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [DATA_W-1:0]         rd_data
);
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = q_flat[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int DATA_W = gpr_pkg::GPR_DATA_W,
  parameter int IDX_W  = gpr_pkg::GPR_IDX_W,
  parameter int POS_RA = gpr_pkg::GPR_IDX_RA,
  parameter int POS_SP = gpr_pkg::GPR_IDX_SP,
  parameter int POS_S0 = gpr_pkg::GPR_IDX_S0,
  parameter int POS_S1 = gpr_pkg::GPR_IDX_S1,
  parameter int POS_S2 = gpr_pkg::GPR_IDX_S2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  output logic [DATA_W-1:0] tap_ra,
  output logic [DATA_W-1:0] tap_sp,
  output logic [DATA_W-1:0] tap_s0,
  output logic [DATA_W-1:0] tap_s1,
  output logic [DATA_W-1:0] tap_s2
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:1]        wr_sel;
  logic [ENTRIES*DATA_W-1:0] q_flat;

  gpr_wr_decode #(.IDX_W(IDX_W), .ENTRIES(ENTRIES)) i_dec (
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_sel (wr_sel)
  );

  gpr_storage #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .q_flat  (q_flat)
  );

  gpr_rd_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ENTRIES(ENTRIES)) i_rd_a (
    .q_flat  (q_flat),
    .rd_idx  (rd_a_idx),
    .rd_data (rd_a_data)
  );

  gpr_rd_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ENTRIES(ENTRIES)) i_rd_b (
    .q_flat  (q_flat),
    .rd_idx  (rd_b_idx),
    .rd_data (rd_b_data)
  );

  assign tap_ra = q_flat[POS_RA*DATA_W +: DATA_W];
  assign tap_sp = q_flat[POS_SP*DATA_W +: DATA_W];
  assign tap_s0 = q_flat[POS_S0*DATA_W +: DATA_W];
  assign tap_s1 = q_flat[POS_S1*DATA_W +: DATA_W];
  assign tap_s2 = q_flat[POS_S2*DATA_W +: DATA_W];
endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  parameter int POS_RA = 1,
  parameter int POS_SP = 2,
  parameter int POS_S0 = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [IDX_W-1:0]  rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic [DATA_W-1:0] tap_ra,
  input logic [DATA_W-1:0] tap_sp,
  input logic [DATA_W-1:0] tap_s0,
  input logic [DATA_W-1:0] tap_s1,
  input logic [DATA_W-1:0] tap_s2
);
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_W'(POS_S0)) |=> (tap_s0 == $past(wr_data)));

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(tap_ra) && $stable(tap_sp) && $stable(tap_s0)
                && $stable(tap_s1) && $stable(tap_s2)));

  assert_other_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx != IDX_W'(POS_RA)) |=> $stable(tap_ra));

  assert_zero_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0) |-> (rd_a_data == '0));

  assert_tap_agrees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == IDX_W'(POS_SP)) |-> (rd_b_data == tap_sp));
endmodule

bind gpr_bank gpr_bank_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W),
  .POS_RA(POS_RA), .POS_SP(POS_SP), .POS_S0(POS_S0)
) i_gpr_bank_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .tap_ra(tap_ra), .tap_sp(tap_sp), .tap_s0(tap_s0),
  .tap_s1(tap_s1), .tap_s2(tap_s2)
);

// File: tb/test_gpr_bank.sv
`timescale 1ns/1ps
module test_gpr_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [15:0] wr_data;
  logic [2:0]  rd_a_idx, rd_b_idx;
  logic [15:0] rd_a_data, rd_b_data;
  logic [15:0] tap_ra, tap_sp, tap_s0, tap_s1, tap_s2;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [8];

  always #5 clk = ~clk;

  gpr_bank i_gpr_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .tap_ra(tap_ra), .tap_sp(tap_sp), .tap_s0(tap_s0),
    .tap_s1(tap_s1), .tap_s2(tap_s2)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Compare every output with the reference array (values before the next edge).
  task automatic check_all();
    chk((rd_a_idx == 0) ? "R5 port A" : "R6 port A", rd_a_data, model[rd_a_idx]);
    chk((rd_b_idx == 0) ? "R5 port B" : "R6 port B", rd_b_data, model[rd_b_idx]);
    chk("R8 tap ra", tap_ra, model[1]);
    chk("R8 tap sp", tap_sp, model[2]);
    chk("R8 tap s0", tap_s0, model[5]);
    chk("R8 tap s1", tap_s1, model[6]);
    chk("R8 tap s2", tap_s2, model[7]);
  endtask

  // Present inputs, check pre-edge outputs, clock, update the model.
  task automatic step(input logic we, input logic [2:0] wi, input logic [15:0] wd,
                      input logic [2:0] ra, input logic [2:0] rb);
    wr_en = we; wr_idx = wi; wr_data = wd; rd_a_idx = ra; rd_b_idx = rb;
    #1;
    check_all();
    @(posedge clk);
    if (we && wi != 3'd0) model[wi] = wd;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 16'h0000;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_a_idx = '0; rd_b_idx = '0;
    repeat (3) @(negedge clk);
    // R1: all entries zero while reset is held
    for (int i = 0; i < 8; i++) begin
      rd_a_idx = 3'(i); #1;
      chk("R1 in reset", rd_a_data, 16'h0000);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rd_b_idx = 3'(i); #1;
      chk("R1 after release", rd_b_data, 16'h0000);
    end

    // R5: write to entry 0 ignored
    step(1'b1, 3'd0, 16'hBEEF, 3'd0, 3'd0);
    rd_a_idx = 3'd0; rd_b_idx = 3'd0; #1;
    chk("R5 zero after write", rd_a_data, 16'h0000);
    chk("R5 zero port B", rd_b_data, 16'h0000);

    // R3: enable low, nothing changes
    step(1'b0, 3'd5, 16'h1234, 3'd5, 3'd5);
    rd_a_idx = 3'd5; #1;
    chk("R3 disabled write", rd_a_data, 16'h0000);
    chk("R3 tap s0 unchanged", tap_s0, 16'h0000);

    // R2/R8: fill entries 1..7 with distinct values
    for (int i = 1; i < 8; i++) step(1'b1, 3'(i), 16'(16'h1100 * i + i), 3'd0, 3'd0);
    for (int i = 1; i < 8; i++) begin
      rd_a_idx = 3'(i); rd_b_idx = 3'(7 - i); #1;
      chk("R2 written value", rd_a_data, 16'(16'h1100 * i + i));
      chk("R6 independent port B", rd_b_data, model[7 - i]);
    end
    check_all();

    // R7: same-cycle read returns the old value, new value after the edge (R2)
    wr_en = 1'b1; wr_idx = 3'd3; wr_data = 16'hA5A5; rd_a_idx = 3'd3; rd_b_idx = 3'd4; #1;
    chk("R7 old value before edge", rd_a_data, model[3]);
    @(posedge clk); model[3] = 16'hA5A5; @(negedge clk);
    wr_en = 1'b0; #1;
    chk("R2 new value after edge", rd_a_data, 16'hA5A5);
    // R4: neighbour untouched
    chk("R4 neighbour kept", rd_b_data, model[4]);

    // Random traffic against the reference array
    for (int n = 0; n < 3000; n++)
      step(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 16'($urandom),
           3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)));
    check_all();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule